// File: doc/BRIEF.md
# Trigger-Linked Up/Down Timer

This block is a general-purpose timer whose counter is paced by a programmable prescaler and wraps at an auto-reload limit. A slave controller, set at run time, decides how the counter is clocked, started, gated or restarted. It can use the internal clock, a trigger input level or edge, or a pair of quadrature encoder inputs. A master selector picks one internal event or reference and drives it onto a trigger output, so that other timers or converters can follow this one.

Software programs the block through a plain synchronous write port (`cfg_we`, `cfg_addr`, `cfg_wdata`). There is no streaming data path, so no pin has valid/ready back-pressure. Every write is accepted in the cycle it is presented. Control and status pins are plain levels or one-cycle pulses. All inputs are synchronous to `clk`. The trigger and encoder inputs are registered once for edge detection, and an edge present before a clock edge acts at that clock edge.

Register map (`cfg_addr`): 0 control (bit0 counter enable, bit1 auto-reload preload enable); 1 prescaler shadow; 2 auto-reload; 3 modes (bits 2:0 slave mode, bits 6:4 master mode); 4 software update request (data ignored). Prescaler width must not exceed counter width, and the counter width must be at least 7.

Top module: `trig_timer`

## Requirements
- R1: After reset the counter reads 0, `upd_flag` and `trig_out` are low, both mode fields are 0, the counter is disabled, the prescaler is 0 and the auto-reload is all ones. Enabling the counter then gives the first update after 2^CNT_W clocks.
- R2: In slave mode 0 (free) with enable set, the counter advances once every prescaler+1 clocks. After holding the auto-reload value it returns to 0 and `upd_flag` is high for one cycle, so updates repeat every (prescaler+1)*(auto-reload+1) clocks. With enable clear the counter holds.
- R3: A write to address 4 clears the counter and prescaler phase, copies the prescaler shadow (and the auto-reload shadow) into the active values, and pulses `upd_flag`. This happens in every slave mode.
- R4: With preload enabled (control bit1), an auto-reload write takes effect only at the next update. With preload disabled, it takes effect on the next clock.
- R5: In slave mode 4 (restart), a rising edge of `trig_in` clears the counter and raises an update that loads the shadow values, whether or not the counter is enabled.
- R6: In slave mode 5 (gated), the counter advances only on clocks where enable is set and `trig_in` is high. It keeps its value while `trig_in` is low.
- R7: In slave mode 6 (start), a rising edge of `trig_in` sets the counter enable without changing the counter value. Clearing enable by a write stops the counter, and a later rising edge resumes it from the held value.
- R8: In slave mode 7 (external clock), with enable set, each rising edge of `trig_in` is one prescaler tick, and the counter does not change on other clocks.
- R9: In slave modes 1 to 3 (encoder, prescaler bypassed, enable required), mode 1 counts toggles of `enc_a`, mode 2 counts toggles of `enc_b`, and mode 3 counts both. An `enc_a` toggle counts up when the new levels of `enc_a` and `enc_b` differ, and an `enc_b` toggle counts up when they are equal; otherwise the count goes down. Counting up from the auto-reload value wraps to 0, and counting down from 0 wraps to the auto-reload value; both wraps pulse `upd_flag`.
- R10: Master modes 0 to 3 drive `trig_out` with, respectively: a one-cycle pulse in the cycle after a software update write; the counter enable; `upd_flag`; and a one-cycle pulse in the cycle after `cmp_ref[0]` rises.
- R11: Master modes 4 to 7 pass `cmp_ref[0]` to `cmp_ref[3]` straight to `trig_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| trig_in | input | 1 | Trigger input for the slave controller |
| enc_a | input | 1 | Encoder input A |
| enc_b | input | 1 | Encoder input B |
| cmp_ref | input | 4 | Compare reference levels |
| trig_out | output | 1 | Trigger output chosen by the master mode |
| cnt_val | output | CNT_W | Counter value |
| upd_flag | output | 1 | One-cycle update event |

## Verification
The hardest case to reach is an auto-reload value written under preload while the counter already sits above it. The new limit must stay pending and then be picked up by an update that the counter itself did not cause. The bench reaches this in restart mode: it writes a small limit mid-count, checks that the counter runs past that limit, and then pulses the trigger input. The update period that follows must match the pending limit. Encoder down-wraps are reached by driving the quadrature sequence in reverse through zero.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  typedef enum logic [2:0] {
    SLV_OFF     = 3'd0,
    SLV_ENC_A   = 3'd1,
    SLV_ENC_B   = 3'd2,
    SLV_ENC_AB  = 3'd3,
    SLV_RESTART = 3'd4,
    SLV_GATE    = 3'd5,
    SLV_START   = 3'd6,
    SLV_EXTCLK  = 3'd7
  } slv_mode_e;

  typedef enum logic [2:0] {
    MST_SWUPD  = 3'd0,
    MST_ENABLE = 3'd1,
    MST_UPDATE = 3'd2,
    MST_CPULSE = 3'd3,
    MST_REF0   = 3'd4,
    MST_REF1   = 3'd5,
    MST_REF2   = 3'd6,
    MST_REF3   = 3'd7
  } mst_mode_e;

  localparam int CFG_AW  = 3;
  localparam int NUM_REF = 4;
  localparam int MST_REF_BASE = 4;

  localparam logic [CFG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [CFG_AW-1:0] A_PSC  = 3'd1;
  localparam logic [CFG_AW-1:0] A_ARR  = 3'd2;
  localparam logic [CFG_AW-1:0] A_MODE = 3'd3;
  localparam logic [CFG_AW-1:0] A_UPD  = 3'd4;
endpackage

// File: rtl/tt_sync_edge.sv
module tt_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] tog
);
  logic [W-1:0] din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  assign tog = din ^ din_q;
endmodule

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CNT_W-1:0]    cfg_wdata,
  input  logic                upd_ev,
  input  logic                start_req,
  output logic                cen,
  output logic [PSC_W-1:0]    psc_act,
  output logic [CNT_W-1:0]    arr_act,
  output slv_mode_e           slv_mode,
  output mst_mode_e           mst_mode,
  output logic                swupd_now,
  output logic                swupd_q
);
  logic             preload;
  logic [PSC_W-1:0] psc_sh;
  logic [CNT_W-1:0] arr_sh;
  logic             wr_ctrl, wr_arr;

  assign swupd_now = cfg_we && (cfg_addr == A_UPD);
  assign wr_ctrl   = cfg_we && (cfg_addr == A_CTRL);
  assign wr_arr    = cfg_we && (cfg_addr == A_ARR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen      <= 1'b0;
      preload  <= 1'b0;
      psc_sh   <= '0;
      arr_sh   <= '1;
      slv_mode <= SLV_OFF;
      mst_mode <= MST_SWUPD;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          A_CTRL: begin
            cen     <= cfg_wdata[0];
            preload <= cfg_wdata[1];
          end
          A_PSC:  psc_sh <= cfg_wdata[PSC_W-1:0];
          A_ARR:  arr_sh <= cfg_wdata;
          A_MODE: begin
            slv_mode <= slv_mode_e'(cfg_wdata[2:0]);
            mst_mode <= mst_mode_e'(cfg_wdata[6:4]);
          end
          default: ;
        endcase
      end
      if (start_req && !wr_ctrl) cen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      arr_act <= '1;
      swupd_q <= 1'b0;
    end else begin
      swupd_q <= swupd_now;
      if (upd_ev) psc_act <= psc_sh;
      if (wr_arr && !preload) arr_act <= cfg_wdata;
      else if (upd_ev)        arr_act <= arr_sh;
    end
  end
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slv_mode_e        slv_mode,
  input  logic             cen,
  input  logic [PSC_W-1:0] psc_act,
  input  logic [CNT_W-1:0] arr_act,
  input  logic             trig_lvl,
  input  logic             trig_rise,
  input  logic [1:0]       enc_lvl,
  input  logic [1:0]       enc_tog,
  input  logic             force_upd,
  output logic [CNT_W-1:0] cnt,
  output logic             upd_ev,
  output logic             upd_flag
);
  logic [PSC_W-1:0] psc_cnt;
  logic tick, psc_wrap, enc_on, use_a, use_b, step_up, step_dn;

  always_comb begin
    case (slv_mode)
      SLV_OFF, SLV_RESTART, SLV_START: tick = cen;
      SLV_GATE:   tick = cen & trig_lvl;
      SLV_EXTCLK: tick = cen & trig_rise;
      default:    tick = 1'b0;
    endcase
    enc_on   = slv_mode inside {SLV_ENC_A, SLV_ENC_B, SLV_ENC_AB};
    use_a    = slv_mode inside {SLV_ENC_A, SLV_ENC_AB};
    use_b    = slv_mode inside {SLV_ENC_B, SLV_ENC_AB};
    psc_wrap = (psc_cnt == psc_act);
    step_up  = 1'b0;
    step_dn  = 1'b0;
    if (enc_on) begin
      if (cen && use_a && enc_tog[0]) begin
        step_up = (enc_lvl[0] != enc_lvl[1]);
        step_dn = (enc_lvl[0] == enc_lvl[1]);
      end else if (cen && use_b && enc_tog[1]) begin
        step_up = (enc_lvl[0] == enc_lvl[1]);
        step_dn = (enc_lvl[0] != enc_lvl[1]);
      end
    end else begin
      step_up = tick && psc_wrap;
    end
    upd_ev = force_upd || (step_up && (cnt == arr_act)) ||
             (step_dn && (cnt == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt  <= '0;
      cnt      <= '0;
      upd_flag <= 1'b0;
    end else begin
      upd_flag <= upd_ev;
      if (force_upd) begin
        psc_cnt <= '0;
        cnt     <= '0;
      end else begin
        if (!enc_on && tick) psc_cnt <= psc_wrap ? '0 : psc_cnt + 1'b1;
        if (step_up)      cnt <= (cnt == arr_act) ? '0 : cnt + 1'b1;
        else if (step_dn) cnt <= (cnt == '0) ? arr_act : cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tt_trgo_sel.sv
module tt_trgo_sel
  import trig_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  mst_mode_e          mst_mode,
  input  logic               swupd_q,
  input  logic               cen,
  input  logic               upd_flag,
  input  logic [NUM_REF-1:0] cmp_ref,
  output logic               trig_out
);
  localparam int NSRC = MST_REF_BASE + NUM_REF;

  logic       ref0_q, cpulse_q;
  logic [NSRC-1:0] src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref0_q   <= 1'b0;
      cpulse_q <= 1'b0;
    end else begin
      ref0_q   <= cmp_ref[0];
      cpulse_q <= cmp_ref[0] & ~ref0_q;
    end
  end

  assign src[MST_SWUPD]  = swupd_q;
  assign src[MST_ENABLE] = cen;
  assign src[MST_UPDATE] = upd_flag;
  assign src[MST_CPULSE] = cpulse_q;

  for (genvar k = 0; k < NUM_REF; k++) begin : g_ref
    assign src[MST_REF_BASE + k] = cmp_ref[k];
  end

  assign trig_out = src[mst_mode];
endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [2:0]                  cfg_addr,
  input  logic [CNT_W-1:0]            cfg_wdata,
  input  logic                        trig_in,
  input  logic                        enc_a,
  input  logic                        enc_b,
  input  logic [3:0]                  cmp_ref,
  output logic                        trig_out,
  output logic [CNT_W-1:0]            cnt_val,
  output logic                        upd_flag
);
  localparam int NEDGE = 3;

  logic [NEDGE-1:0] edge_tog;
  logic             trig_rise;
  logic             cen, swupd_now, swupd_q, upd_ev, start_req, force_upd;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_act;
  slv_mode_e        slv_mode;
  mst_mode_e        mst_mode;

  tt_sync_edge #(.W(NEDGE)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({trig_in, enc_b, enc_a}),
    .tog   (edge_tog)
  );

  assign trig_rise = edge_tog[2] & trig_in;
  assign start_req = (slv_mode == SLV_START) && trig_rise;
  assign force_upd = swupd_now || ((slv_mode == SLV_RESTART) && trig_rise);

  tt_cfg_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .upd_ev    (upd_ev),
    .start_req (start_req),
    .cen       (cen),
    .psc_act   (psc_act),
    .arr_act   (arr_act),
    .slv_mode  (slv_mode),
    .mst_mode  (mst_mode),
    .swupd_now (swupd_now),
    .swupd_q   (swupd_q)
  );

  tt_count_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .slv_mode  (slv_mode),
    .cen       (cen),
    .psc_act   (psc_act),
    .arr_act   (arr_act),
    .trig_lvl  (trig_in),
    .trig_rise (trig_rise),
    .enc_lvl   ({enc_b, enc_a}),
    .enc_tog   (edge_tog[1:0]),
    .force_upd (force_upd),
    .cnt       (cnt_val),
    .upd_ev    (upd_ev),
    .upd_flag  (upd_flag)
  );

  tt_trgo_sel u_trgo (
    .clk      (clk),
    .rst_n    (rst_n),
    .mst_mode (mst_mode),
    .swupd_q  (swupd_q),
    .cen      (cen),
    .upd_flag (upd_flag),
    .cmp_ref  (cmp_ref),
    .trig_out (trig_out)
  );
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input slv_mode_e        slv,
  input mst_mode_e        mst,
  input logic             trig_in,
  input logic             trig_rise,
  input logic             cen,
  input logic [CNT_W-1:0] cnt_val,
  input logic             upd_flag,
  input logic             trig_out
);
  logic slv_enc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slv_enc_d <= 1'b0;
    else        slv_enc_d <= slv inside {SLV_ENC_A, SLV_ENC_B, SLV_ENC_AB};
  end

  assert_free_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slv == SLV_OFF && !cfg_we) |=>
      (upd_flag || (CNT_W'(cnt_val - $past(cnt_val)) <= CNT_W'(1))));

  assert_upd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_flag && !slv_enc_d) |-> (cnt_val == '0));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slv == SLV_RESTART && trig_rise && !cfg_we) |=> (cnt_val == '0 && upd_flag));

  assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slv == SLV_GATE && !trig_in && !cfg_we) |=> $stable(cnt_val));

  assert_start_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slv == SLV_START && trig_rise && !cfg_we) |=> cen);

  assert_ext_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slv == SLV_EXTCLK && !trig_rise && !cfg_we) |=> $stable(cnt_val));

  assert_mst_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mst == MST_UPDATE) |-> (trig_out == upd_flag));
endmodule

bind trig_timer tt_checker #(.CNT_W(CNT_W)) u_tt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .slv       (slv_mode),
  .mst       (mst_mode),
  .trig_in   (trig_in),
  .trig_rise (trig_rise),
  .cen       (cen),
  .cnt_val   (cnt_val),
  .upd_flag  (upd_flag),
  .trig_out  (trig_out)
);

// File: tb/test_trig_timer.sv
module test_trig_timer;
  localparam int CW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          trig_in = 1'b0;
  logic          enc_a = 1'b0;
  logic          enc_b = 1'b0;
  logic [3:0]    cmp_ref = '0;
  logic          trig_out, upd_flag;
  logic [CW-1:0] cnt_val;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  trig_timer #(.CNT_W(CW), .PSC_W(PW)) i_trig_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_in(trig_in), .enc_a(enc_a), .enc_b(enc_b),
    .cmp_ref(cmp_ref), .trig_out(trig_out), .cnt_val(cnt_val), .upd_flag(upd_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = CW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int slv, input int mst, input int psc, input int arr, input int ctrl);
    wr(1, psc);
    wr(2, arr);
    wr(3, (mst << 4) | slv);
    wr(0, ctrl);
    wr(4, 0);
  endtask

  task automatic measure(output int p);
    int g = 0;
    while (!upd_flag && g < 5000) begin @(negedge clk); g++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!upd_flag && p < 5000);
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1; @(negedge clk);
    trig_in = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p, g, exp, s, pa, pb, na, nb, mism;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt_val, 0);
    chk("R1 upd", upd_flag, 0);
    chk("R1 trig_out", trig_out, 0);
    wr(0, 1);
    g = 0;
    while (!upd_flag && g < 1000) begin @(negedge clk); g++; end
    chk("R1 first wrap after full range", g, 256);

    // R2 period sweep in free mode
    for (int ps = 0; ps < 3; ps++)
      for (int ar = 0; ar < 5; ar++) begin
        setup(0, 0, ps, ar, 1);
        measure(p);
        chk("R2 period", p, (ps + 1) * (ar + 1));
      end
    setup(0, 0, 0, 255, 1);
    chk("R3 cnt cleared by sw update", cnt_val, 0);
    chk("R3 upd pulse on sw update", upd_flag, 1);
    repeat (7) @(negedge clk);
    chk("R2 cnt after 7 clocks", cnt_val, 7);
    wr(0, 0);
    repeat (4) @(negedge clk);
    chk("R2 hold when disabled", cnt_val, 8);

    // R4 preload disabled: immediate
    setup(0, 0, 0, 255, 1);
    repeat (3) @(negedge clk);
    wr(2, 20);
    measure(p);
    chk("R4 immediate auto-reload", p, 21);

    // R5 restart mode with R4 preload held
    setup(4, 0, 0, 255, 3);
    repeat (10) @(negedge clk);
    chk("R5 counting", cnt_val, 10);
    trig_in = 1'b1; @(negedge clk);
    chk("R5 cnt cleared", cnt_val, 0);
    chk("R5 update", upd_flag, 1);
    trig_in = 1'b0; @(negedge clk);
    chk("R5 resumes", cnt_val, 1);
    chk("R5 single pulse", upd_flag, 0);
    wr(2, 5);
    repeat (8) @(negedge clk);
    chk("R4 preload pending, cnt past new limit", cnt_val, 10);
    trig_in = 1'b1; @(negedge clk);
    trig_in = 1'b0;
    measure(p);
    chk("R4 R5 shadow loaded by trigger", p, 6);

    // R6 gated
    setup(5, 0, 0, 255, 1);
    repeat (5) @(negedge clk);
    chk("R6 low gate holds", cnt_val, 0);
    trig_in = 1'b1;
    repeat (7) @(negedge clk);
    trig_in = 1'b0;
    chk("R6 counted while high", cnt_val, 7);
    repeat (5) @(negedge clk);
    chk("R6 keeps value", cnt_val, 7);

    // R7 start mode, master mode 1 shows enable (R10)
    setup(6, 1, 0, 255, 0);
    chk("R10 enable low", trig_out, 0);
    repeat (4) @(negedge clk);
    chk("R7 idle before trigger", cnt_val, 0);
    trig_in = 1'b1; @(negedge clk);
    chk("R10 enable set by trigger", trig_out, 1);
    chk("R7 no reset at start", cnt_val, 0);
    repeat (5) @(negedge clk);
    chk("R7 counting", cnt_val, 5);
    wr(0, 0);
    repeat (3) @(negedge clk);
    chk("R7 stopped by write", cnt_val, 6);
    trig_in = 1'b0; @(negedge clk);
    trig_in = 1'b1; @(negedge clk);
    chk("R7 restart keeps value", cnt_val, 6);
    repeat (4) @(negedge clk);
    chk("R7 resumed", cnt_val, 10);
    trig_in = 1'b0;

    // R8 external clock
    setup(7, 0, 0, 255, 1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 9; i++) pulse_trig();
    chk("R8 one step per edge", cnt_val, 9);
    setup(7, 0, 2, 255, 1);
    for (int i = 0; i < 9; i++) pulse_trig();
    chk("R8 prescaled edges", cnt_val, 3);
    setup(7, 0, 0, 4, 1);
    for (int i = 0; i < 13; i++) pulse_trig();
    chk("R8 wrap", cnt_val, 3);

    // R9 encoder modes; states (a,b): 00,10,11,01
    for (int m = 1; m <= 3; m++) begin
      setup(m, 0, 3, 9, 1);
      exp = 0; s = 0;
      for (int dir = 0; dir < 2; dir++)
        for (int i = 0; i < 12; i++) begin
          pa = (s == 1 || s == 2); pb = (s == 2 || s == 3);
          s = (dir == 0) ? (s + 1) % 4 : (s + 3) % 4;
          na = (s == 1 || s == 2); nb = (s == 2 || s == 3);
          enc_a = 1'(na); enc_b = 1'(nb);
          if (na != pa && m != 2) begin
            if (na != nb) exp = (exp == 9) ? 0 : exp + 1;
            else          exp = (exp == 0) ? 9 : exp - 1;
          end else if (nb != pb && m != 1) begin
            if (na == nb) exp = (exp == 9) ? 0 : exp + 1;
            else          exp = (exp == 0) ? 9 : exp - 1;
          end
          @(negedge clk);
          chk("R9 encoder count", cnt_val, exp);
        end
    end

    // R10 master mode 0: software update pulse
    setup(0, 0, 0, 255, 1);
    chk("R10 sw update pulse", trig_out, 1);
    @(negedge clk);
    chk("R10 sw update pulse ends", trig_out, 0);
    // R10 master mode 2: update event
    setup(0, 2, 0, 2, 1);
    mism = 0;
    for (int i = 0; i < 12; i++) begin
      if (trig_out != upd_flag) mism++;
      @(negedge clk);
    end
    chk("R10 update mirror mismatches", mism, 0);
    // R10 master mode 3: compare pulse
    setup(0, 3, 0, 255, 1);
    cmp_ref[0] = 1'b1; @(negedge clk);
    chk("R10 compare pulse", trig_out, 1);
    @(negedge clk);
    chk("R10 compare pulse one cycle", trig_out, 0);
    cmp_ref = '0;
    // R11 reference pass-through
    for (int k = 0; k < 4; k++) begin
      wr(3, (4 + k) << 4);
      for (int v = 0; v < 16; v++) begin
        cmp_ref = 4'(v);
        #1;
        chk("R11 reference routed", trig_out, (v >> k) & 1);
        @(negedge clk);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule